// File: doc/BRIEF.md
# GOP Picture Type Sequencer

This block decides the coding type of every frame of a video encoder's group of pictures, in display order. Software loads a reference distance M (1 to 3), a group length N (1 to 19) and one of three group modes. The encoder then pulses a frame tick once per incoming frame. After each tick the block presents a descriptor for that frame: its picture type, its position in the group, whether it opens a group, whether its B prediction must look backward only, and whether it is a P frame that should get B-style quantiser weighting.

The three modes are real closed, backward-predicted closed and open. In real closed mode the group begins with the I frame. The other two modes place M−1 B frames ahead of the I frame. In backward-predicted closed mode those leading B frames use references inside their own group only. In open mode they may use the previous group's last P frame, except in the first group after a load or restart, where they are forced backward-only. If a loaded configuration has no defined pattern, the block raises a sticky error and ignores ticks until a valid configuration is loaded.

Top module: `gop_seq`

## Requirements
- R1: After reset: `pic_o`=0 (none), `frame_idx_o`=0, and `frame_stb_o`, `gop_start_o`, `bwd_only_o`, `virt_b_o` and `cfg_err_o` are all 0.
- R2: `frame_stb_o` pulses in the cycle after a tick only while a valid configuration is active. Before the first load, ticks produce no strobe.
- R3: With M=1 the group is an I frame followed by N−1 P frames. M=1 with N=1 gives I frames only. The picture type codes are I=1, P=2, B=3.
- R4: In real closed mode (mode 0) with M≥2, frame k is I at k=0, P when k is a nonzero multiple of M, and B otherwise. The configuration is valid only when (N−1) mod M = 0.
- R5: In backward-closed mode (mode 1) and open mode (mode 2) with M≥2, frames 0 to M−2 are B. With j=k−(M−1): frame k is I at j=0, P when j is a nonzero multiple of M, and B otherwise. The configuration is valid only when N mod M = 0.
- R6: `bwd_only_o` is 1 exactly on leading B frames. In mode 1 this applies to every group. In mode 2 it applies only to the first group after a load or restart.
- R7: With M=1, `virt_b_o` is 1 on every P frame with an even index (the 2nd, 4th and so on), and 0 on all other frames.
- R8: `frame_idx_o` steps 0 to N−1 and then wraps to 0. `gop_start_o` pulses together with the strobe for index 0.
- R9: A load of M outside 1..3, N outside 1..19, mode 3, or a failed divisibility rule sets `cfg_err_o`. The error persists and ticks are ignored until a valid load clears it.
- R10: A `restart_i` pulse makes the next tick (including a tick in the same cycle) emit index 0 in the first-group state.
- R11: A valid load during a run restarts the group at index 0 in the first-group state. A tick in the same cycle as a load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load and validate configuration |
| cfg_m_i | input | 2 | Reference frame distance M |
| cfg_n_i | input | 5 | Group length N |
| cfg_mode_i | input | 2 | 0 real closed, 1 backward closed, 2 open, 3 reserved |
| restart_i | input | 1 | Restart sequence at next tick |
| frame_tick_i | input | 1 | One pulse per frame |
| frame_stb_o | output | 1 | Descriptor updated |
| pic_o | output | 2 | Picture type: 0 none, 1 I, 2 P, 3 B |
| frame_idx_o | output | 5 | Frame index in group |
| gop_start_o | output | 1 | First frame of a group |
| bwd_only_o | output | 1 | Backward-only prediction for this B frame |
| virt_b_o | output | 1 | P frame takes B quantiser weighting |
| cfg_err_o | output | 1 | Sticky invalid configuration |

## Verification
The hardest case to reach is open mode crossing a group boundary. There, the leading B frames are backward-only in the first group but not in the second, and a restart must bring that state back in the middle of a group. The bench sweeps every M, N (including out-of-range values) and mode. For each valid load it ticks through more than two groups while counting frames since the load, so the first-group and later-group cases are both checked. A separate sequence restarts in the middle of a later group, restarts in the same cycle as a tick, and reloads during a run.

// File: rtl/gop_seq_pkg.sv
package gop_seq_pkg;
  typedef enum logic [1:0] {PIC_NONE = 2'd0, PIC_I = 2'd1, PIC_P = 2'd2, PIC_B = 2'd3} pic_e;
  typedef enum logic [1:0] {MODE_CLOSED = 2'd0, MODE_BWD = 2'd1, MODE_OPEN = 2'd2, MODE_RSVD = 2'd3} gop_mode_e;
endpackage

// File: rtl/gop_cfg_check.sv
module gop_cfg_check
  import gop_seq_pkg::*;
#(
  parameter int M_W   = 2,
  parameter int IDX_W = 5,
  parameter int M_MAX = 3,
  parameter int N_MAX = 19
) (
  input  logic [M_W-1:0]   m_i,
  input  logic [IDX_W-1:0] n_i,
  input  logic [1:0]       mode_i,
  output logic             ok_o,
  output logic [M_W-1:0]   lead_o
);
  logic [IDX_W-1:0] div;
  logic [IDX_W-1:0] rem_n, rem_nm1;
  logic             range_ok;

  assign div      = (m_i == '0) ? IDX_W'(1) : IDX_W'(m_i);
  assign rem_n    = n_i % div;
  assign rem_nm1  = (n_i - IDX_W'(1)) % div;
  assign range_ok = (m_i != '0) && (32'(m_i) <= M_MAX) && (n_i != '0) && (32'(n_i) <= N_MAX);

  always_comb begin
    ok_o   = 1'b0;
    lead_o = '0;
    if (range_ok) begin
      unique case (gop_mode_e'(mode_i))
        MODE_CLOSED: ok_o = (rem_nm1 == '0);
        MODE_BWD, MODE_OPEN: begin
          ok_o   = (rem_n == '0);
          lead_o = m_i - M_W'(1);
        end
        default: ok_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gop_frame_classify.sv
module gop_frame_classify
  import gop_seq_pkg::*;
#(
  parameter int M_W   = 2,
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [M_W-1:0]   m_i,
  input  logic [M_W-1:0]   lead_i,
  input  logic [1:0]       mode_i,
  input  logic             first_i,
  output pic_e             pic_o,
  output logic             bwd_o,
  output logic             virt_o
);
  logic [IDX_W-1:0] j, div, rem;
  logic             leading;

  assign leading = idx_i < IDX_W'(lead_i);
  assign j       = idx_i - IDX_W'(lead_i);
  assign div     = (m_i == '0) ? IDX_W'(1) : IDX_W'(m_i);
  assign rem     = j % div;

  always_comb begin
    if (leading)          pic_o = PIC_B;
    else if (j == '0)     pic_o = PIC_I;
    else if (rem == '0)   pic_o = PIC_P;
    else                  pic_o = PIC_B;
  end

  // leading B frames: always self-contained in bwd mode, only first group in open mode
  assign bwd_o  = leading && ((gop_mode_e'(mode_i) == MODE_BWD) ||
                              ((gop_mode_e'(mode_i) == MODE_OPEN) && first_i));
  assign virt_o = (m_i == M_W'(1)) && (idx_i != '0) && !idx_i[0];
endmodule

// File: rtl/gop_seq.sv
module gop_seq
  import gop_seq_pkg::*;
#(
  parameter int M_MAX = 3,
  parameter int N_MAX = 19,
  localparam int M_W   = $clog2(M_MAX + 1),
  localparam int IDX_W = $clog2(N_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_load_i,
  input  logic [M_W-1:0]   cfg_m_i,
  input  logic [IDX_W-1:0] cfg_n_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             restart_i,
  input  logic             frame_tick_i,
  output logic             frame_stb_o,
  output logic [1:0]       pic_o,
  output logic [IDX_W-1:0] frame_idx_o,
  output logic             gop_start_o,
  output logic             bwd_only_o,
  output logic             virt_b_o,
  output logic             cfg_err_o
);
  logic [M_W-1:0]   m_q, lead_q, lead_d;
  logic [IDX_W-1:0] n_q, nidx_q, cur_idx;
  logic [1:0]       mode_q;
  logic             active_q, first_q, rpend_q, cfg_ok;
  logic             cur_rst, cur_first, cur_last, c_bwd, c_virt;
  pic_e             c_pic;

  gop_cfg_check #(.M_W(M_W), .IDX_W(IDX_W), .M_MAX(M_MAX), .N_MAX(N_MAX)) u_cfg (
    .m_i   (cfg_m_i),
    .n_i   (cfg_n_i),
    .mode_i(cfg_mode_i),
    .ok_o  (cfg_ok),
    .lead_o(lead_d)
  );

  assign cur_rst   = rpend_q | restart_i;
  assign cur_idx   = cur_rst ? '0 : nidx_q;
  assign cur_first = cur_rst | first_q;
  assign cur_last  = (cur_idx == n_q - IDX_W'(1));

  gop_frame_classify #(.M_W(M_W), .IDX_W(IDX_W)) u_cls (
    .idx_i  (cur_idx),
    .m_i    (m_q),
    .lead_i (lead_q),
    .mode_i (mode_q),
    .first_i(cur_first),
    .pic_o  (c_pic),
    .bwd_o  (c_bwd),
    .virt_o (c_virt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= '0; n_q <= '0; mode_q <= '0; lead_q <= '0;
      active_q <= 1'b0; cfg_err_o <= 1'b0;
      nidx_q <= '0; first_q <= 1'b1; rpend_q <= 1'b0;
      frame_stb_o <= 1'b0; gop_start_o <= 1'b0;
      pic_o <= PIC_NONE; frame_idx_o <= '0;
      bwd_only_o <= 1'b0; virt_b_o <= 1'b0;
    end else begin
      frame_stb_o <= 1'b0;
      gop_start_o <= 1'b0;
      if (cfg_load_i) begin
        m_q <= cfg_m_i; n_q <= cfg_n_i; mode_q <= cfg_mode_i; lead_q <= lead_d;
        active_q  <= cfg_ok;
        cfg_err_o <= !cfg_ok;
        nidx_q    <= '0;
        first_q   <= 1'b1;
        rpend_q   <= 1'b0;
      end else if (frame_tick_i && active_q) begin
        frame_stb_o <= 1'b1;
        gop_start_o <= (cur_idx == '0);
        pic_o       <= c_pic;
        frame_idx_o <= cur_idx;
        bwd_only_o  <= c_bwd;
        virt_b_o    <= c_virt;
        nidx_q      <= cur_last ? '0 : cur_idx + IDX_W'(1);
        first_q     <= cur_first && !cur_last;
        rpend_q     <= 1'b0;
      end else if (restart_i) begin
        rpend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gop_seq_chk.sv
module gop_seq_chk
  import gop_seq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_load_i,
  input logic             frame_tick_i,
  input logic             frame_stb_o,
  input logic [1:0]       pic_o,
  input logic [IDX_W-1:0] frame_idx_o,
  input logic             gop_start_o,
  input logic             bwd_only_o,
  input logic             virt_b_o,
  input logic             cfg_err_o
);
  AST_VIRT_ON_P: assert property (@(posedge clk_i) disable iff (!rst_ni)
    virt_b_o |-> pic_o == PIC_P); // R7
  AST_BWD_ON_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bwd_only_o |-> pic_o == PIC_B); // R6
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o && !cfg_load_i |=> cfg_err_o); // R9
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !frame_stb_o); // R9
  AST_GOP_IDX0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gop_start_o |-> frame_stb_o && frame_idx_o == '0); // R8
  AST_IDX_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o && !gop_start_o |-> frame_idx_o != '0); // R8
  AST_NO_TICK_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_tick_i |=> !frame_stb_o); // R2
  AST_LOAD_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> !frame_stb_o); // R11
endmodule

bind gop_seq gop_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_load_i  (cfg_load_i),
  .frame_tick_i(frame_tick_i),
  .frame_stb_o (frame_stb_o),
  .pic_o       (pic_o),
  .frame_idx_o (frame_idx_o),
  .gop_start_o (gop_start_o),
  .bwd_only_o  (bwd_only_o),
  .virt_b_o    (virt_b_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/gop_seq_tb.sv
module gop_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0, restart = 1'b0, tick = 1'b0;
  logic [1:0] m = '0, mode = '0;
  logic [4:0] n = '0;
  logic       stb, gstart, bwd, virt, err;
  logic [1:0] pic;
  logic [4:0] idx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gop_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(load), .cfg_m_i(m), .cfg_n_i(n),
    .cfg_mode_i(mode), .restart_i(restart), .frame_tick_i(tick),
    .frame_stb_o(stb), .pic_o(pic), .frame_idx_o(idx), .gop_start_o(gstart),
    .bwd_only_o(bwd), .virt_b_o(virt), .cfg_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit cfg_valid(int mm, int nn, int md);
    if (mm < 1 || mm > 3 || nn < 1 || nn > 19 || md == 3) return 0;
    if (md == 0) return ((nn - 1) % mm) == 0;
    return (nn % mm) == 0;
  endfunction

  function automatic int lead_of(int mm, int md);
    return (md == 0 || mm == 1) ? 0 : mm - 1;
  endfunction

  function automatic int exp_pic(int mm, int md, int k);
    int l, j;
    l = lead_of(mm, md);
    if (k < l) return 3;
    j = k - l;
    if (j == 0) return 1;
    if (j % mm == 0) return 2;
    return 3;
  endfunction

  task automatic do_load(input int mm, input int nn, input int md);
    @(negedge clk);
    m = 2'(mm); n = 5'(nn); mode = 2'(md); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_tick(input bit with_restart);
    @(negedge clk);
    tick = 1'b1; restart = with_restart;
    @(negedge clk);
    tick = 1'b0; restart = 1'b0;
  endtask

  // check descriptor against model: k frame index, first = in first group
  task automatic chk_frame(input int mm, input int md, input int k, input bit first);
    int ep;
    bit eb, ev;
    ep = exp_pic(mm, md, k);
    eb = (k < lead_of(mm, md)) && (md == 1 || (md == 2 && first));
    ev = (mm == 1) && (k != 0) && (k % 2 == 0);
    chk(stb == 1'b1, "R2 strobe", int'(stb), 1);
    chk(int'(pic) == ep, (mm == 1) ? "R3 type" : (md == 0 ? "R4 type" : "R5 type"), int'(pic), ep);
    chk(int'(idx) == k, "R8 index", int'(idx), k);
    chk(gstart == (k == 0), "R8 gop_start", int'(gstart), int'(k == 0));
    chk(bwd == eb, "R6 bwd_only", int'(bwd), int'(eb));
    chk(virt == ev, "R7 virt_b", int'(virt), int'(ev));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stb == 0 && gstart == 0 && bwd == 0 && virt == 0, "R1 flags", int'({stb, gstart, bwd, virt}), 0);
    chk(pic == 2'd0 && idx == 5'd0, "R1 pic/idx", int'({pic, idx}), 0);
    chk(err == 0, "R1 err", int'(err), 0);
    rst_n = 1'b1;
    // R2 no strobe before a load
    do_tick(1'b0);
    chk(stb == 0, "R2 tick before load", int'(stb), 0);

    // sweep all configurations, R3 R4 R5 R6 R7 R8 R9
    for (int mm = 0; mm < 4; mm++) begin
      for (int nn = 0; nn < 22; nn++) begin
        for (int md = 0; md < 4; md++) begin
          bit v;
          v = cfg_valid(mm, nn, md);
          do_load(mm, nn, md);
          chk(err == !v, "R9 error flag", int'(err), int'(!v));
          if (v) begin
            for (int f = 0; f < 2 * nn + 1; f++) begin
              do_tick(1'b0);
              chk_frame(mm, md, f % nn, f < nn);
            end
          end else begin
            do_tick(1'b0);
            chk(stb == 0, "R9 tick ignored", int'(stb), 0);
            chk(err == 1, "R9 error sticky", int'(err), 1);
          end
        end
      end
    end

    // R10 restart in a later group, open mode M=3 N=6
    do_load(3, 6, 2);
    chk(err == 0, "R9 valid load clears error", int'(err), 0);
    for (int f = 0; f < 8; f++) do_tick(1'b0);
    chk(int'(idx) == 1 && bwd == 0, "R6 second group not bwd", int'(bwd), 0);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    do_tick(1'b0);
    chk_frame(3, 2, 0, 1'b1);  // R10
    do_tick(1'b0);
    chk_frame(3, 2, 1, 1'b1);  // R10
    for (int f = 2; f < 8; f++) do_tick(1'b0);
    chk(int'(idx) == 1 && bwd == 0, "R10 back to later group", int'(bwd), 0);
    do_tick(1'b1);             // R10 restart with tick
    chk_frame(3, 2, 0, 1'b1);
    // R11 reload during run, tick in the load cycle ignored
    do_tick(1'b0); do_tick(1'b0); do_tick(1'b0);
    @(negedge clk);
    m = 2'd3; n = 5'd6; mode = 2'd2; load = 1'b1; tick = 1'b1;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
    chk(stb == 0, "R11 tick with load ignored", int'(stb), 0);
    do_tick(1'b0);
    chk_frame(3, 2, 0, 1'b1);  // R11
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule